// File: doc/BRIEF.md
# Four-Mode Plant Supervisor

This block is a synchronous discrete supervisor that tracks which of four operating modes a heated plant is in. The modes are cold shutdown, heatup, power operation and emergency trip. A continuous-layer monitor sends six boolean predicates: a minimum-temperature flag, a temperature-in-band flag, a power-above-critical flag, a heatup health invariant, a run health invariant and an operator reset. The supervisor samples them once per clock and moves the mode one step.

When more than one guard is true, a fixed safety priority decides: a trip condition always wins over progress and over staying put. Emergency trip is not a permanent latch. The plant leaves it only through an explicit operator reset, which returns it to cold shutdown. The block outputs a 2-bit mode code, four one-hot mode flags and a one-cycle strobe on each entry into trip.

Named states: `MODE_COLD` (0), `MODE_HEAT` (1), `MODE_RUN` (2), `MODE_TRIP` (3). Named transitions: *warm* (COLD→HEAT), *go-live* (HEAT→RUN), *heat-trip* (HEAT→TRIP), *run-trip* (RUN→TRIP), *rearm* (TRIP→COLD). Every other case is a self-loop.

Top module: `mode_supervisor`

## Requirements
- R1: `mode` always carries a known value, encoded as cold shutdown = 0, heatup = 1, power operation = 2, emergency trip = 3.
- R2: `rst` is synchronous and active high. A clock edge with `rst` high sets `mode` to 0 and `trip_pulse` to 0, whatever the predicate inputs are.
- R3: In cold shutdown, `temp_min_ok` high moves the mode to heatup at the next edge. With `temp_min_ok` low, the mode stays in cold shutdown.
- R4: In heatup, when `inv_heat_ok`, `temp_in_band` and `power_crit` are all high, the mode moves to power operation at the next edge.
- R5: In heatup, `inv_heat_ok` low moves the mode to emergency trip at the next edge, even when `temp_in_band` and `power_crit` are both high.
- R6: In heatup, when `inv_heat_ok` is high and `temp_in_band` and `power_crit` are not both high, the mode stays in heatup.
- R7: In power operation, the mode stays while `inv_run_ok` is high. With `inv_run_ok` low, it moves to emergency trip at the next edge.
- R8: In emergency trip, the mode stays while `op_reset` is low. With `op_reset` high, it moves to cold shutdown at the next edge.
- R9: Exactly one of `in_shutdown`, `in_heatup`, `in_operation`, `in_trip` is high in every cycle, and it is the flag that matches `mode`.
- R10: `temp_min_ok` affects only cold shutdown, `inv_heat_ok` only heatup, `inv_run_ok` only power operation, and `op_reset` only emergency trip. In any other mode these inputs do not change the next mode.
- R11: `trip_pulse` is high for exactly the first cycle in which `mode` is 3 after any other mode, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_min_ok | input | 1 | Average temperature above the minimum |
| temp_in_band | input | 1 | Average temperature inside the operating band |
| power_crit | input | 1 | Power above critical |
| inv_heat_ok | input | 1 | Heatup safety invariant holds |
| inv_run_ok | input | 1 | Power-operation safety invariant holds |
| op_reset | input | 1 | Operator rearm command |
| mode | output | 2 | Current mode code |
| in_shutdown | output | 1 | High in cold shutdown |
| in_heatup | output | 1 | High in heatup |
| in_operation | output | 1 | High in power operation |
| in_trip | output | 1 | High in emergency trip |
| trip_pulse | output | 1 | One-cycle strobe on entry into trip |

## Verification
Predicates sampled at one rising edge show up in `mode` and in the mode flags straight after that edge, because a single register lies on the path. `trip_pulse` has its own register, which is loaded at the same edge, so it rises in the same cycle as `mode` first shows 3. The bench drives inputs on the falling edge and samples every output 5 ns after the following rising edge. At that point it compares them with a model that it advances once per edge. Directed sequences cover every named transition, the trip-over-progress priority, the ignored inputs and a reset taken while in trip. A seeded random run then mixes all six predicates.

// File: rtl/modesup_pkg.sv
package modesup_pkg;
    localparam int NUM_MODES = 4;
    localparam int MODE_W    = $clog2(NUM_MODES);

    typedef enum logic [MODE_W-1:0] {
        MODE_COLD = 2'd0,
        MODE_HEAT = 2'd1,
        MODE_RUN  = 2'd2,
        MODE_TRIP = 2'd3
    } mode_e;

    typedef struct packed {
        logic temp_min_ok;
        logic temp_in_band;
        logic power_crit;
        logic inv_heat_ok;
        logic inv_run_ok;
        logic op_reset;
    } guard_t;
endpackage

// File: rtl/modesup_next.sv
module modesup_next
    import modesup_pkg::*;
(
    input  mode_e  cur,
    input  guard_t g,
    output mode_e  nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            MODE_COLD: nxt = g.temp_min_ok ? MODE_HEAT : MODE_COLD;
            MODE_HEAT: begin
                if (!g.inv_heat_ok)                       nxt = MODE_TRIP;
                else if (g.temp_in_band && g.power_crit)  nxt = MODE_RUN;
                else                                      nxt = MODE_HEAT;
            end
            MODE_RUN:  nxt = g.inv_run_ok ? MODE_RUN : MODE_TRIP;
            MODE_TRIP: nxt = g.op_reset ? MODE_COLD : MODE_TRIP;
            default:   nxt = MODE_COLD;
        endcase
    end
endmodule

// File: rtl/modesup_decode.sv
module modesup_decode
    import modesup_pkg::*;
(
    input  logic [MODE_W-1:0]    code,
    output logic [NUM_MODES-1:0] hot
);
    for (genvar i = 0; i < NUM_MODES; i++) begin : g_hot
        assign hot[i] = (code == MODE_W'(i));
    end
endmodule

// File: rtl/mode_supervisor.sv
module mode_supervisor
    import modesup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       temp_min_ok,
    input  logic       temp_in_band,
    input  logic       power_crit,
    input  logic       inv_heat_ok,
    input  logic       inv_run_ok,
    input  logic       op_reset,
    output logic [1:0] mode,
    output logic       in_shutdown,
    output logic       in_heatup,
    output logic       in_operation,
    output logic       in_trip,
    output logic       trip_pulse
);
    guard_t                g;
    mode_e                 mode_q, mode_d;
    logic                  pulse_q;
    logic [NUM_MODES-1:0]  hot;

    assign g = '{temp_min_ok:  temp_min_ok,
                 temp_in_band: temp_in_band,
                 power_crit:   power_crit,
                 inv_heat_ok:  inv_heat_ok,
                 inv_run_ok:   inv_run_ok,
                 op_reset:     op_reset};

    modesup_next u_next (.cur(mode_q), .g(g), .nxt(mode_d));

    // State register plus trip-entry strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_COLD;
            pulse_q <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            pulse_q <= (mode_d == MODE_TRIP) && (mode_q != MODE_TRIP);
        end
    end

    modesup_decode u_dec (.code(mode_q), .hot(hot));

    // Output process
    always_comb begin
        mode         = mode_q;
        in_shutdown  = hot[MODE_COLD];
        in_heatup    = hot[MODE_HEAT];
        in_operation = hot[MODE_RUN];
        in_trip      = hot[MODE_TRIP];
        trip_pulse   = pulse_q;
    end

    assert_mode_known_R1: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(mode));
    assert_reset_cold_R2: assert property (@(posedge clk)
        rst |=> (mode == 2'd0) && !trip_pulse);
    assert_warm_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && temp_min_ok) |=> mode == 2'd1);
    assert_cold_stay_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && !temp_min_ok) |=> mode == 2'd0);
    assert_golive_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && inv_heat_ok && temp_in_band && power_crit) |=> mode == 2'd2);
    assert_heat_trip_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && !inv_heat_ok) |=> mode == 2'd3);
    assert_heat_stay_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && inv_heat_ok && !(temp_in_band && power_crit)) |=> mode == 2'd1);
    assert_run_stay_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && inv_run_ok) |=> mode == 2'd2);
    assert_run_trip_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && !inv_run_ok) |=> mode == 2'd3);
    assert_trip_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && !op_reset) |=> mode == 2'd3);
    assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && op_reset) |=> mode == 2'd0);
    assert_flags_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $countones({in_shutdown, in_heatup, in_operation, in_trip}) == 1);
    assert_flag_match_R9: assert property (@(posedge clk) disable iff (rst)
        in_trip == (mode == 2'd3) && in_shutdown == (mode == 2'd0));
    assert_pulse_entry_R11: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd3) ##1 (mode == 2'd3) |-> trip_pulse);
    assert_pulse_only_entry_R11: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |-> (mode == 2'd3) && ($past(mode) != 2'd3));
endmodule

// File: tb/sim_mode_supervisor.sv
module sim_mode_supervisor;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic temp_min_ok = 0, temp_in_band = 0, power_crit = 0;
    logic inv_heat_ok = 0, inv_run_ok = 0, op_reset = 0;
    logic [1:0] mode;
    logic in_shutdown, in_heatup, in_operation, in_trip, trip_pulse;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_mode = 2'd0;
    logic       exp_pulse = 1'b0;
    bit         done = 0;

    always #10 clk = ~clk;   // 50 MHz

    mode_supervisor u0 (.*);

    // Reference next mode, written from R3..R8
    function automatic logic [1:0] ref_next(input logic [1:0] m, input logic [5:0] v);
        // v = {op_reset, inv_run_ok, inv_heat_ok, power_crit, temp_in_band, temp_min_ok}
        case (m)
            2'd0: return v[0] ? 2'd1 : 2'd0;
            2'd1: return !v[3] ? 2'd3 : ((v[1] && v[2]) ? 2'd2 : 2'd1);
            2'd2: return v[4] ? 2'd2 : 2'd3;
            default: return v[5] ? 2'd0 : 2'd3;
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] m, input logic [5:0] v);
        case (m)
            2'd0: return "R3";
            2'd1: return !v[3] ? "R5" : ((v[1] && v[2]) ? "R4" : "R6");
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [5:0] v, input logic do_rst, input string tag_over);
        string t;
        @(negedge clk);
        rst = do_rst;
        {op_reset, inv_run_ok, inv_heat_ok, power_crit, temp_in_band, temp_min_ok} = v;
        t = (tag_over != "") ? tag_over : (do_rst ? "R2" : tag_for(exp_mode, v));
        @(posedge clk);
        if (do_rst) begin
            exp_mode  = 2'd0;
            exp_pulse = 1'b0;
        end else begin
            logic [1:0] n;
            n = ref_next(exp_mode, v);
            exp_pulse = (n == 2'd3) && (exp_mode != 2'd3);
            exp_mode  = n;
        end
        #5;
        chk(t, {2'b0, mode}, {2'b0, exp_mode});
        chk("R1", {3'b0, ^mode === 1'bx}, 4'd0);
        chk("R9", {in_trip, in_operation, in_heatup, in_shutdown},
            4'(1) << exp_mode);
        chk("R11", {3'b0, trip_pulse}, {3'b0, exp_pulse});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        // R2: reset with every predicate high
        step(6'b111111, 1'b1, "R2");
        step(6'b111111, 1'b1, "R2");
        // Walk the named transitions
        step(6'b000000, 1'b0, "R3");   // cold stays
        step(6'b001001, 1'b0, "R3");   // warm
        step(6'b001010, 1'b0, "R6");   // band only: stay heat
        step(6'b001101, 1'b0, "R6");   // critical only: stay heat
        step(6'b000110, 1'b0, "R5");   // invariant fails with progress: trip wins
        step(6'b011110, 1'b0, "R8");   // trip held without rearm
        step(6'b100000, 1'b0, "R8");   // rearm
        step(6'b000001, 1'b0, "R3");   // warm
        step(6'b001110, 1'b0, "R4");   // go-live
        // R10: foreign inputs in power operation
        step(6'b110001, 1'b0, "R10");
        step(6'b110100, 1'b0, "R10");
        step(6'b000110, 1'b0, "R7");   // run-trip
        // R10: foreign inputs in trip
        step(6'b011111, 1'b0, "R10");
        // R2: reset taken while in trip, no rearm
        step(6'b000000, 1'b1, "R2");
        // R10: foreign inputs in cold
        step(6'b111110, 1'b0, "R10");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] v;
            v[0] = ($urandom % 2) == 0;
            v[1] = ($urandom % 3) != 0;
            v[2] = ($urandom % 3) != 0;
            v[3] = ($urandom % 10) != 0;
            v[4] = ($urandom % 10) != 0;
            v[5] = ($urandom % 8) == 0;
            step(v, ($urandom % 200) == 0, "");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule